// File: doc/BRIEF.md
# Per-Channel Transceiver Analog Setting Controller

This block holds the analog tuning values for a small group of transceiver lanes and lets a host change or inspect them one lane at a time. Every lane keeps a 3-bit transmit output-swing code and a 3-bit receive equalizer code in shadow registers. The host picks a lane with a binary lane index, picks the transmit half, the receive half or both with a 2-bit side selector, and then pulses a write or a read strobe for one clock.

Each accepted request occupies the controller for a fixed number of clocks. This stands in for the serial transfer to the analog macro. A busy flag covers that window, and the host waits for busy to be low before it issues the next request. A write lands in the shadow registers when busy falls. A read places the lane's stored codes on the read-back ports in that same cycle and marks them with a one-cycle valid pulse.

Top module: `reconf_ctrl`

## Requirements
- R1: After reset every lane's swing and equalizer codes are zero, `busy` and `rd_valid` are low, and both read-back ports show zero.
- R2: A `wr_stb` or `rd_stb` sampled high while `busy` is low is accepted. `busy` is high from the next cycle for exactly ACCESS_CYCLES (default 8) cycles.
- R3: A strobe sampled while `busy` is high is ignored. It changes no stored code, does not lengthen the busy window and produces no `rd_valid`.
- R4: Side selector bit 1 enables the transmit half. A write with `side_sel` = 2'b10 stores `tx_swing_wr` into the addressed lane and leaves that lane's equalizer code unchanged.
- R5: Side selector bit 0 enables the receive half. With 2'b01 only the equalizer code is written, and with 2'b11 both codes are written.
- R6: `side_sel` = 2'b00 is an empty request. It still runs the full busy window but changes no stored code. On a read, `rd_valid` still pulses and both read-back ports keep their previous values.
- R7: A write affects only the lane selected by `lane_idx` (width log2 of LANES, 2 bits for 4 lanes). All other lanes keep their codes.
- R8: A read updates `tx_swing_rd` from the addressed lane only when bit 1 is set, and `rx_eq_rd` only when bit 0 is set. An unselected port and both ports between reads hold their last value.
- R9: `rd_valid` is a single-cycle pulse, high in the first cycle `busy` is low after an accepted read. It never follows a write.
- R10: When `wr_stb` and `rd_stb` are both high at acceptance, the request is a write. No `rd_valid` follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_stb | input | 1 | One-cycle write request |
| rd_stb | input | 1 | One-cycle read request |
| lane_idx | input | 2 | Lane index (log2 LANES) |
| side_sel | input | 2 | Bit 1 transmit half, bit 0 receive half |
| tx_swing_wr | input | 3 | Swing code to write |
| rx_eq_wr | input | 3 | Equalizer code to write |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | Read-back ports valid, one-cycle pulse |
| tx_swing_rd | output | 3 | Swing code read back |
| rx_eq_rd | output | 3 | Equalizer code read back |

## Verification
The bench builds the block with its default parameters: four lanes, 3-bit codes and an 8-cycle access window. With four lanes every index value can be written with a distinct code and read back, so a decoding fault on any lane shows up. The short window lets the bench count the busy length cycle by cycle and insert a strobe in the middle of an access. The bench also covers all four side-selector encodings, read-back hold behaviour, and the collision of write and read strobes.

// File: rtl/reconf_pkg.sv
package reconf_pkg;
  // Side selector: bit 1 selects the transmit half, bit 0 the receive half.
  typedef struct packed {
    logic tx;
    logic rx;
  } side_t;

  function automatic int addr_width(input int lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction
endpackage

// File: rtl/reconf_seq.sv
module reconf_seq #(
  parameter int ACCESS_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_stb_i,
  input  logic rd_stb_i,
  output logic busy_o,
  output logic accept_o,
  output logic done_o,
  output logic is_rd_o,
  output logic rd_valid_o
);
  localparam int CNT_W = $clog2(ACCESS_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACCESS_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rd_q, rd_d;
  logic             vld_q, vld_d;

  assign accept_o = !busy_q && (wr_stb_i || rd_stb_i);
  assign done_o   = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    rd_d   = rd_q;
    vld_d  = 1'b0;
    if (!busy_q) begin
      if (accept_o) begin
        busy_d = 1'b1;
        cnt_d  = LAST;
        rd_d   = rd_stb_i && !wr_stb_i;  // write wins a collision
      end
    end else if (cnt_q == '0) begin
      busy_d = 1'b0;
      vld_d  = rd_q;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      rd_q   <= rd_d;
      vld_q  <= vld_d;
    end
  end

  assign busy_o     = busy_q;
  assign is_rd_o    = rd_q;
  assign rd_valid_o = vld_q;

  p_accept_raises_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (wr_stb_i || rd_stb_i)) |=> busy_o);

  p_window_not_cut_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  p_valid_on_busy_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (!busy_o && $past(busy_o)));

  p_valid_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  p_collision_no_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wr_stb_i) |=> !is_rd_o);
endmodule

// File: rtl/reconf_bank.sv
module reconf_bank #(
  parameter int LANES  = 4,
  parameter int SW_W   = 3,
  parameter int EQ_W   = 3,
  parameter int ADDR_W = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic                       tx_en_i,
  input  logic                       rx_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [SW_W-1:0]            tx_wd_i,
  input  logic [EQ_W-1:0]            rx_wd_i,
  output logic [LANES-1:0][SW_W-1:0] tx_all_o,
  output logic [LANES-1:0][EQ_W-1:0] rx_all_o
);
  logic [LANES-1:0][SW_W-1:0] tx_q;
  logic [LANES-1:0][EQ_W-1:0] rx_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    logic tx_ce, rx_ce;
    assign hit   = commit_i && (addr_i == ADDR_W'(g));
    assign tx_ce = hit && tx_en_i;
    assign rx_ce = hit && rx_en_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tx_q[g] <= '0;
      end else if (tx_ce) begin
        tx_q[g] <= tx_wd_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rx_q[g] <= '0;
      end else if (rx_ce) begin
        rx_q[g] <= rx_wd_i;
      end
    end
  end

  assign tx_all_o = tx_q;
  assign rx_all_o = rx_q;

  p_hold_without_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(tx_all_o) && $stable(rx_all_o)));

  p_empty_side_no_change_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !rx_en_i) |=> ($stable(tx_all_o) && $stable(rx_all_o)));
endmodule

// File: rtl/reconf_ctrl.sv
module reconf_ctrl #(
  parameter int LANES         = 4,
  parameter int SW_W          = 3,
  parameter int EQ_W          = 3,
  parameter int ACCESS_CYCLES = 8,
  parameter int ADDR_W        = reconf_pkg::addr_width(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] lane_idx,
  input  logic [1:0]        side_sel,
  input  logic [SW_W-1:0]   tx_swing_wr,
  input  logic [EQ_W-1:0]   rx_eq_wr,
  output logic              busy,
  output logic              rd_valid,
  output logic [SW_W-1:0]   tx_swing_rd,
  output logic [EQ_W-1:0]   rx_eq_rd
);
  import reconf_pkg::*;

  logic accept, done, is_rd;

  reconf_seq #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_seq (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_stb_i  (wr_stb),
    .rd_stb_i  (rd_stb),
    .busy_o    (busy),
    .accept_o  (accept),
    .done_o    (done),
    .is_rd_o   (is_rd),
    .rd_valid_o(rd_valid)
  );

  // Request held for the whole access window.
  logic [ADDR_W-1:0] addr_q;
  side_t             side_q;
  logic [SW_W-1:0]   txw_q;
  logic [EQ_W-1:0]   rxw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      side_q <= '0;
      txw_q  <= '0;
      rxw_q  <= '0;
    end else if (accept) begin
      addr_q <= lane_idx;
      side_q <= side_t'(side_sel);
      txw_q  <= tx_swing_wr;
      rxw_q  <= rx_eq_wr;
    end
  end

  logic [LANES-1:0][SW_W-1:0] tx_all;
  logic [LANES-1:0][EQ_W-1:0] rx_all;

  reconf_bank #(
    .LANES (LANES),
    .SW_W  (SW_W),
    .EQ_W  (EQ_W),
    .ADDR_W(ADDR_W)
  ) u_bank (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .commit_i(done && !is_rd),
    .tx_en_i (side_q.tx),
    .rx_en_i (side_q.rx),
    .addr_i  (addr_q),
    .tx_wd_i (txw_q),
    .rx_wd_i (rxw_q),
    .tx_all_o(tx_all),
    .rx_all_o(rx_all)
  );

  // Read-back registers.
  logic [SW_W-1:0] txr_q, txr_d;
  logic [EQ_W-1:0] rxr_q, rxr_d;

  always_comb begin
    txr_d = txr_q;
    rxr_d = rxr_q;
    if (done && is_rd) begin
      if (side_q.tx) txr_d = tx_all[addr_q];
      if (side_q.rx) rxr_d = rx_all[addr_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txr_q <= '0;
      rxr_q <= '0;
    end else begin
      txr_q <= txr_d;
      rxr_q <= rxr_d;
    end
  end

  assign tx_swing_rd = txr_q;
  assign rx_eq_rd    = rxr_q;

  p_readback_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> ($stable(tx_swing_rd) && $stable(rx_eq_rd)));

  p_no_readback_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_rd) |=> !rd_valid);
endmodule

// File: tb/reconf_ctrl_tb.sv
module reconf_ctrl_tb;
  localparam int LANES = 4;
  localparam int SW_W  = 3;
  localparam int EQ_W  = 3;
  localparam int ACC   = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n, wr_stb, rd_stb;
  logic [1:0]      lane_idx, side_sel;
  logic [SW_W-1:0] tx_swing_wr, tx_swing_rd;
  logic [EQ_W-1:0] rx_eq_wr, rx_eq_rd;
  logic            busy, rd_valid;

  reconf_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .lane_idx(lane_idx), .side_sel(side_sel), .tx_swing_wr(tx_swing_wr),
    .rx_eq_wr(rx_eq_wr), .busy(busy), .rd_valid(rd_valid),
    .tx_swing_rd(tx_swing_rd), .rx_eq_rd(rx_eq_rd)
  );

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  typedef struct {
    logic [SW_W-1:0] tx;
    logic [EQ_W-1:0] rx;
    string           tag;
  } exp_t;
  exp_t sb[$];

  logic [SW_W-1:0] m_tx [LANES];
  logic [EQ_W-1:0] m_rx [LANES];
  logic [SW_W-1:0] exp_tx;
  logic [EQ_W-1:0] exp_rx;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pop expected read-back items as rd_valid appears.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "rd_valid without pending read", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(tx_swing_rd == e.tx, e.tag, "tx_swing_rd", int'(tx_swing_rd), int'(e.tx));
        check(rx_eq_rd == e.rx, e.tag, "rx_eq_rd", int'(rx_eq_rd), int'(e.rx));
      end
    end
  end

  // Driver: one request, model update, busy window and valid pulse checks.
  task automatic txn(input bit wr, input bit rd, input int ch, input logic [1:0] side,
                     input logic [SW_W-1:0] tx, input logic [EQ_W-1:0] rx,
                     input string tag);
    int n;
    @(negedge clk);
    wr_stb = wr; rd_stb = rd; lane_idx = 2'(ch); side_sel = side;
    tx_swing_wr = tx; rx_eq_wr = rx;
    if (wr) begin
      if (side[1]) m_tx[ch] = tx;
      if (side[0]) m_rx[ch] = rx;
    end else if (rd) begin
      if (side[1]) exp_tx = m_tx[ch];
      if (side[0]) exp_rx = m_rx[ch];
      sb.push_back('{exp_tx, exp_rx, tag});
    end
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == ACC, "R2", "busy window length", n, ACC);
    check(rd_valid == (rd && !wr), wr ? "R9/R10" : "R9", "rd_valid at busy fall",
          int'(rd_valid), int'(rd && !wr));
    @(negedge clk);
    check(!rd_valid, "R9", "rd_valid single pulse", int'(rd_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0; lane_idx = '0; side_sel = '0;
    tx_swing_wr = '0; rx_eq_wr = '0;
    exp_tx = '0; exp_rx = '0;
    for (int i = 0; i < LANES; i++) begin m_tx[i] = '0; m_rx[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!busy, "R1", "busy after reset", int'(busy), 0);
    check(!rd_valid, "R1", "rd_valid after reset", int'(rd_valid), 0);
    check(tx_swing_rd == 0 && rx_eq_rd == 0, "R1", "read-back after reset",
          int'({tx_swing_rd, rx_eq_rd}), 0);
    for (int i = 0; i < LANES; i++) txn(0, 1, i, 2'b11, 0, 0, "R1");

    // R4 transmit-only write
    txn(1, 0, 0, 2'b10, 3'd7, 3'd5, "R4");
    txn(0, 1, 0, 2'b11, 0, 0, "R4");
    // R5 receive-only and both
    txn(1, 0, 1, 2'b01, 3'd3, 3'd6, "R5");
    txn(0, 1, 1, 2'b11, 0, 0, "R5");
    txn(1, 0, 2, 2'b11, 3'd1, 3'd2, "R5");
    txn(0, 1, 2, 2'b11, 0, 0, "R5");
    // R6 empty write and empty read
    txn(1, 0, 3, 2'b00, 3'd5, 3'd5, "R6");
    txn(0, 1, 3, 2'b11, 0, 0, "R6");
    txn(0, 1, 2, 2'b11, 0, 0, "R8");
    txn(0, 1, 0, 2'b00, 0, 0, "R6");
    // R8 partial read-back holds the other port
    txn(0, 1, 0, 2'b10, 0, 0, "R8");
    txn(0, 1, 1, 2'b01, 0, 0, "R8");
    @(negedge clk);
    check(tx_swing_rd == 3'd7 && rx_eq_rd == 3'd6, "R8", "read-back held between reads",
          int'({tx_swing_rd, rx_eq_rd}), int'({3'd7, 3'd6}));

    // R7 lane decoding
    for (int i = 0; i < LANES; i++) txn(1, 0, i, 2'b11, 3'(i + 2), 3'(6 - i), "R7");
    for (int i = LANES - 1; i >= 0; i--) txn(0, 1, i, 2'b11, 0, 0, "R7");

    // R3 strobes during busy are ignored
    @(negedge clk);
    wr_stb = 1'b1; lane_idx = 2'd1; side_sel = 2'b10; tx_swing_wr = 3'd6; rx_eq_wr = 3'd0;
    m_tx[1] = 3'd6;
    @(negedge clk);
    n = busy ? 1 : 0;
    wr_stb = 1'b1; rd_stb = 1'b1; lane_idx = 2'd1; side_sel = 2'b11;
    tx_swing_wr = 3'd1; rx_eq_wr = 3'd7;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == ACC, "R3", "busy window with intruding strobe", n, ACC);
    check(!rd_valid, "R3", "no rd_valid from ignored read", int'(rd_valid), 0);
    @(negedge clk);
    txn(0, 1, 1, 2'b11, 0, 0, "R3");

    // R10 write and read strobes together
    txn(1, 1, 3, 2'b11, 3'd4, 3'd4, "R10");
    txn(0, 1, 3, 2'b11, 0, 0, "R10");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R9", "reads left without rd_valid", sb.size(), 0);
    done_flag = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule